// File: doc/BRIEF.md
# Channel Enable Gate with Fault Request

This block sits between a hardware enable pin, the per-channel enable bits of a two-channel output driver, and the driver's active-low open-drain fault line. Software sets or clears each channel's enable bit through a simple write strobe. The effective output enable of a channel is its stored bit, qualified by the synchronized enable pin and by the absence of a latched watchdog trip.

A low enable pin does more than mask the outputs. It actively clears the stored enable bits, so software must write them again once the pin has returned high. Writes stay accepted while the pin is low, but the clear overrides them. A watchdog trip latches an internal reset: outputs are forced off, the bits are cleared, writes are refused and the fault line is held low. Only the active-low reset input leaves that state.

The fault request is low whenever any of these holds: reset is held, the watchdog lock is set, a diagnosed fault is present, or the enable pin is low while the fault-mask bit is 1.

Top module: `chan_enable_gate`

## Requirements
- R1: While `rst_n` is low, `en_bits` and `chan_on` are all zero and `fault_n` is 0.
- R2: A write with `wr_strobe[c]`=1 sampled at a clock edge loads `wr_data[c]` into bit c of `en_bits`, visible after that edge. With the pin high and no watchdog lock, `chan_on[c]` then equals that bit.
- R3: The enable pin passes through a two-flop synchronizer. `chan_on` goes to zero after the second rising edge that samples the pin low.
- R4: While the synchronized pin is low, every bit of `en_bits` is cleared, from the third rising edge after the pin falls.
- R5: After the pin returns high, `en_bits` stays zero until software writes a 1.
- R6: A write of 1 in a cycle where the synchronized pin is low leaves the bit at 0; the clear takes priority.
- R7: A low enable pin drives `fault_n` low (after the two synchronizer edges) only when `fault_mask` is 1. With `fault_mask` 0, the pin alone leaves `fault_n` at 1.
- R8: `diag_fault`=1 drives `fault_n` low in the same cycle, without waiting for a clock edge.
- R9: A `wd_trip` pulse sampled at an edge sets a sticky lock. From that edge on, `chan_on` is zero and `fault_n` is 0. `en_bits` is cleared at the next edge, and writes are ignored until `rst_n` goes low.
- R10: A write strobe for one channel leaves the other channel's bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset input |
| en_pin | input | 1 | Asynchronous hardware enable pin |
| fault_mask | input | 1 | 1: a low enable pin is reported on the fault line |
| diag_fault | input | 1 | Diagnosed fault present |
| wd_trip | input | 1 | Watchdog expiry pulse |
| wr_strobe | input | NCH | Per-channel write strobe |
| wr_data | input | NCH | Per-channel write value |
| en_bits | output | NCH | Stored enable bits (read-back) |
| chan_on | output | NCH | Effective channel output enable |
| fault_n | output | 1 | Active-low fault request (open-drain level) |

## Verification
The pin-driven clear and a software write can land on the same edge. The bench provokes this by letting the pin fall, waiting until the synchronized level is low, and then strobing a write of 1. It passes only if the bit reads 0 after the edge. A second collision puts the watchdog lock against a write, and the written value must never appear in `en_bits`.

// File: rtl/chan_gate_pkg.sv
package chan_gate_pkg;
  localparam int unsigned NCH_DEFAULT = 2;
  localparam int unsigned SYNC_DEPTH  = 2;

  // fault request is asserted when any cause is present
  function automatic logic fault_cause(input logic rst_hold, input logic wd_lock,
                                       input logic diag, input logic mask,
                                       input logic pin_ok);
    return rst_hold | wd_lock | diag | (mask & ~pin_ok);
  endfunction

  // outputs are allowed only with pin high and no lock
  function automatic logic drive_allowed(input logic pin_ok, input logic wd_lock);
    return pin_ok & ~wd_lock;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync_o
);
  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[DEPTH-2:0], pin_async};
  end

  assign pin_sync_o = chain_q[DEPTH-1];
endmodule

// File: rtl/wd_latch.sv
module wd_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_trip,
  output logic wd_lock
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wd_lock <= 1'b0;
    else if (wd_trip) wd_lock <= 1'b1;
  end

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_lock |=> wd_lock);
endmodule

// File: rtl/chan_en_bank.sv
module chan_en_bank #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pin_ok,
  input  logic           wd_lock,
  input  logic [NCH-1:0] wr_strobe,
  input  logic [NCH-1:0] wr_data,
  output logic [NCH-1:0] bits_q
);
  logic clear_all;
  assign clear_all = ~chan_gate_pkg::drive_allowed(pin_ok, wd_lock);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            bits_q[c] <= 1'b0;
      else if (clear_all)    bits_q[c] <= 1'b0;
      else if (wr_strobe[c]) bits_q[c] <= wr_data[c];
    end

    // R5
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bits_q[c] && !(wr_strobe[c] && wr_data[c])) |=> !bits_q[c]);
  end

  // R4
  pin_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_ok |=> (bits_q == '0));
endmodule

// File: rtl/fault_drive.sv
module fault_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_lock,
  input  logic diag_fault,
  input  logic fault_mask,
  input  logic pin_ok,
  output logic fault_n
);
  assign fault_n = ~chan_gate_pkg::fault_cause(~rst_n, wd_lock, diag_fault,
                                               fault_mask, pin_ok);

  // R8
  diag_pulls_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_fault |-> !fault_n);

  // R7
  unmasked_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_mask && !wd_lock && !diag_fault) |-> fault_n);
endmodule

// File: rtl/chan_enable_gate.sv
module chan_enable_gate #(
  parameter int unsigned NCH = chan_gate_pkg::NCH_DEFAULT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_pin,
  input  logic           fault_mask,
  input  logic           diag_fault,
  input  logic           wd_trip,
  input  logic [NCH-1:0] wr_strobe,
  input  logic [NCH-1:0] wr_data,
  output logic [NCH-1:0] en_bits,
  output logic [NCH-1:0] chan_on,
  output logic           fault_n
);
  logic pin_ok;
  logic wd_lock;
  logic drive_ok;

  pin_sync #(.DEPTH(chan_gate_pkg::SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(en_pin), .pin_sync_o(pin_ok));

  wd_latch u_wd (.clk(clk), .rst_n(rst_n), .wd_trip(wd_trip), .wd_lock(wd_lock));

  chan_en_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .pin_ok(pin_ok), .wd_lock(wd_lock),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .bits_q(en_bits));

  fault_drive u_fault (
    .clk(clk), .rst_n(rst_n), .wd_lock(wd_lock), .diag_fault(diag_fault),
    .fault_mask(fault_mask), .pin_ok(pin_ok), .fault_n(fault_n));

  assign drive_ok = chan_gate_pkg::drive_allowed(pin_ok, wd_lock);
  assign chan_on  = en_bits & {NCH{drive_ok}};

  // R9
  lock_outputs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_lock |-> (chan_on == '0) && !fault_n);

  // R1
  reset_hold_chk: assert property (@(posedge clk)
    !rst_n |-> (en_bits == '0) && (chan_on == '0) && !fault_n);
endmodule

// File: tb/chan_enable_gate_tb.sv
module chan_enable_gate_tb;
  localparam int NCH = 2;
  logic clk = 1'b0;
  logic rst_n, en_pin, fault_mask, diag_fault, wd_trip;
  logic [NCH-1:0] wr_strobe, wr_data, en_bits, chan_on;
  logic fault_n;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  chan_enable_gate #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .fault_mask(fault_mask),
    .diag_fault(diag_fault), .wd_trip(wd_trip), .wr_strobe(wr_strobe),
    .wr_data(wr_data), .en_bits(en_bits), .chan_on(chan_on), .fault_n(fault_n));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d expected<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance n edges, land on the following falling edge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [NCH-1:0] s, input logic [NCH-1:0] d);
    wr_strobe = s; wr_data = d;
    step(1);
    wr_strobe = '0; wr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en_pin = 1'b1; fault_mask = 1'b0; diag_fault = 1'b0;
    wd_trip = 1'b0; wr_strobe = '0; wr_data = '0;
    step(2);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 en_bits", en_bits, 0);
    chk("R1 chan_on", chan_on, 0);
    chk("R1 fault_n", fault_n, 0);
    rst_n = 1'b1;
    step(3);
    chk("R1 fault_n released", fault_n, 1);
  endtask

  task automatic t_write();
    wr(2'b01, 2'b01);
    chk("R2 bits ch0", en_bits, 2'b01);
    chk("R2 chan_on ch0", chan_on, 2'b01);
    wr(2'b10, 2'b10);
    chk("R10 ch1 set keeps ch0", en_bits, 2'b11);
    wr(2'b01, 2'b00);
    chk("R10 ch0 clear keeps ch1", en_bits, 2'b10);
    chk("R2 chan_on follows", chan_on, 2'b10);
  endtask

  task automatic t_pin_low();
    wr(2'b11, 2'b11);
    en_pin = 1'b0;
    step(1);
    chk("R3 one edge still on", chan_on, 2'b11);
    step(1);
    chk("R3 two edges off", chan_on, 2'b00);
    chk("R7 mask0 fault_n high", fault_n, 1);
    step(1);
    chk("R4 bits cleared", en_bits, 2'b00);
    en_pin = 1'b1;
    step(4);
    chk("R5 bits stay zero", en_bits, 2'b00);
    chk("R5 chan_on stays off", chan_on, 2'b00);
    wr(2'b11, 2'b11);
    chk("R5 rewrite restores", chan_on, 2'b11);
  endtask

  task automatic t_collide();
    wr(2'b11, 2'b00);
    en_pin = 1'b0;
    step(2);
    wr(2'b11, 2'b11);
    chk("R6 clear beats write", en_bits, 2'b00);
    en_pin = 1'b1;
    step(3);
    chk("R6 no late effect", en_bits, 2'b00);
  endtask

  task automatic t_mask();
    fault_mask = 1'b1;
    en_pin = 1'b0;
    step(1);
    chk("R7 mask1 one edge high", fault_n, 1);
    step(1);
    chk("R7 mask1 pin low", fault_n, 0);
    en_pin = 1'b1;
    step(2);
    chk("R7 mask1 pin back", fault_n, 1);
    fault_mask = 1'b0;
  endtask

  task automatic t_diag();
    diag_fault = 1'b1;
    #1;
    chk("R8 diag immediate", fault_n, 0);
    step(1);
    diag_fault = 1'b0;
    #1;
    chk("R8 diag removed", fault_n, 1);
  endtask

  task automatic t_wd();
    wr(2'b11, 2'b11);
    wd_trip = 1'b1;
    step(1);
    wd_trip = 1'b0;
    chk("R9 chan_on off", chan_on, 2'b00);
    chk("R9 fault_n low", fault_n, 0);
    step(1);
    chk("R9 bits cleared", en_bits, 2'b00);
    wr(2'b11, 2'b11);
    chk("R9 write ignored", en_bits, 2'b00);
    step(3);
    chk("R9 lock sticky", fault_n, 0);
    rst_n = 1'b0;
    step(1);
    rst_n = 1'b1;
    step(3);
    chk("R9 reset clears lock", fault_n, 1);
    wr(2'b01, 2'b01);
    chk("R9 writes after reset", chan_on, 2'b01);
  endtask

  initial begin
    do_reset();
    t_reset();
    do_reset(); t_write();
    do_reset(); t_pin_low();
    do_reset(); t_collide();
    do_reset(); t_mask();
    do_reset(); t_diag();
    do_reset(); t_wd();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule